// File: doc/BRIEF.md
# I2C Master Byte Receiver with Acknowledge Wait

This block is the receive half of an I2C master. Once the bus is addressed and the slave is ready to send, software drives it through a small register interface. It selects receive mode and then reads the data register. That read is a dummy read that launches eight receive clocks on SCL. The block samples SDA in the middle of each high phase and shifts the bits in. It then issues a ninth clock, during which it returns an acknowledge level that software has selected.

With wait mode enabled, the block pauses every byte after the eighth clock. It holds SCL low and raises the interrupt flag, and it releases the ninth clock only after software clears that flag. Software can use the pause to choose whether the byte is acknowledged, and so end a transfer with a not-acknowledge. When the ninth clock rises, the byte moves to the data register and the completion flag is set. The read that collects the byte also launches the next one. Switching back to transmit mode before that read stops reception.

SCL and SDA are open-drain: an output enable pulls the line low. A slave that holds SCL low stalls the phase timer. The SCL high and low phases each last `PHASE_CYCLES` system clocks.

Top module: `i2c_rx_wait_master`

## Requirements
- R1: After reset, both pins are released, `irq` is 0, the status register (address 2: bit0 = interrupt flag, bit1 = byte-complete flag) reads 0x00, and the control register (address 1: bit0 = transmit mode, bit1 = wait enable, bit2 = send not-acknowledge, bit3 = interrupt enable) reads 0x01.
- R2: A read of the data register (address 0) with control bit0 = 0 starts eight receive clocks. The same read with bit0 = 1 starts nothing. Once a byte has completed, no further clock is issued until the next data-register read in receive mode.
- R3: The eight bits are sampled MSB first at the middle of each SCL high phase, and the completed byte is returned by the data register.
- R4: In wait mode, the interrupt flag is set when SCL falls after the 8th clock. SCL then stays low, and no 9th clock is issued, for as long as the flag stays set.
- R5: During the 9th clock, SDA is driven low when control bit2 = 0 and left released when bit2 = 1.
- R6: On the rise of the 9th clock, the interrupt flag and the byte-complete flag are both set.
- R7: `irq` is 1 exactly while the interrupt flag is 1 and control bit3 = 1.
- R8: A data-register read clears the byte-complete flag.
- R9: While a slave holds SCL low, the phase timer stops. After the release, the high phase still lasts `PHASE_CYCLES` clocks, and the received data is unaffected.
- R10: Writing 0 to status bit0 clears the interrupt flag. Writing 1 there leaves the flag unchanged.
- R11: With wait mode off, the interrupt flag is not set at the 8th clock, and the 9th clock follows at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostAddr | input | 2 | Register select: 0 data, 1 control, 2 status |
| hostWr | input | 1 | Register write strobe |
| hostWrData | input | 8 | Write data |
| hostRd | input | 1 | Register read strobe (side effects on the data register) |
| hostRdData | output | 8 | Read data of the selected register |
| irq | output | 1 | Interrupt request |
| sclIn | input | 1 | Sensed SCL line level |
| sclOe | output | 1 | Pull SCL low when 1 |
| sdaIn | input | 1 | Sensed SDA line level |
| sdaOe | output | 1 | Pull SDA low when 1 |

## Verification
The slave model sends directed bytes first: all zeros, all ones and an alternating pattern. These show whether the shift order and SDA sampling are right, and whether the released SDA level is read correctly. Seeded random bytes follow, each with its own mix of wait mode, acknowledge level and interrupt enable. This separates the pause and flag timing of wait mode from the flow without a pause, and catches an acknowledge level or irq gating that was mixed up. One byte is stretched by the slave to show that the phase timer stalls. A read in transmit mode, and the idle time after the last byte, show that clocks start only on a data read in receive mode.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,     // SCL released, not yet started
    ST_LOW,      // data clock low phase
    ST_HIGH,     // data clock high phase
    ST_WAIT,     // paused after 8th clock, SCL held low
    ST_ACKLOW,   // 9th clock low phase
    ST_ACKHIGH,  // 9th clock high phase
    ST_PARK      // byte done, SCL held low until next read
  } rxState_t;

  typedef struct packed {
    logic sampleBit;  // shift SDA into the byte
    logic waitMark;   // raise flag at 8th fall in wait mode
    logic byteDone;   // 9th clock rose: commit byte, raise flags
  } rxStrobe_t;

endpackage

// File: rtl/i2c_rx_ctrl.sv
module i2c_rx_ctrl
  import i2c_rx_pkg::*;
#(
  parameter int PHASE_CYCLES = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      waitEn,
  input  logic      ackHigh,
  input  logic      intFlag,
  input  logic      sclIn,
  output rxStrobe_t stb,
  output logic      sclOe,
  output logic      sdaOe,
  output rxState_t  state
);

  localparam int CNT_W = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PHASE_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(PHASE_CYCLES / 2);

  logic [CNT_W-1:0] cnt;
  logic [2:0]       bitIdx;
  logic             phaseEnd;
  logic             ackPhase;

  assign phaseEnd = (cnt == CNT_LAST);
  assign ackPhase = (state == ST_ACKLOW) || (state == ST_ACKHIGH);

  always_comb begin
    stb.sampleBit = (state == ST_HIGH) && sclIn && (cnt == CNT_MID);
    stb.waitMark  = (state == ST_HIGH) && sclIn && phaseEnd && (bitIdx == 3'd7) && waitEn;
    stb.byteDone  = (state == ST_ACKHIGH) && sclIn && (cnt == '0);
    sclOe = (state == ST_LOW) || (state == ST_WAIT) || (state == ST_ACKLOW) || (state == ST_PARK);
    sdaOe = ackPhase && !ackHigh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE, ST_PARK: begin
          if (startReq) begin
            state  <= ST_LOW;
            cnt    <= '0;
            bitIdx <= '0;
          end
        end
        ST_LOW: begin
          if (phaseEnd) begin
            state <= ST_HIGH;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_HIGH: begin
          if (sclIn) begin
            if (phaseEnd) begin
              cnt <= '0;
              if (bitIdx == 3'd7) begin
                state <= waitEn ? ST_WAIT : ST_ACKLOW;
              end else begin
                bitIdx <= bitIdx + 3'd1;
                state  <= ST_LOW;
              end
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
        ST_WAIT: begin
          if (!intFlag) begin
            state <= ST_ACKLOW;
            cnt   <= '0;
          end
        end
        ST_ACKLOW: begin
          if (phaseEnd) begin
            state <= ST_ACKHIGH;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_ACKHIGH: begin
          if (sclIn) begin
            if (phaseEnd) begin
              state <= ST_PARK;
              cnt   <= '0;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_rx_datapath.sv
module i2c_rx_datapath
  import i2c_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              sdaIn,
  input  rxStrobe_t         stb,
  output logic              startReq,
  output logic              xmitMode,
  output logic              waitEn,
  output logic              ackHigh,
  output logic              irqEn,
  output logic              intFlag,
  output logic              rxDone,
  output logic              irq
);

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] dataReg;
  logic              dataRead;
  logic              unusedWrBits;

  assign unusedWrBits = ^wrData[DATA_W-1:4];
  assign dataRead     = rdEn && (addr == ADDR_DATA);
  assign startReq     = dataRead && !xmitMode;
  assign irq          = intFlag && irqEn;

  always_comb begin
    rdData = '0;
    unique case (addr)
      ADDR_DATA: rdData = dataReg;
      ADDR_CTRL: rdData = DATA_W'({irqEn, ackHigh, waitEn, xmitMode});
      ADDR_STAT: rdData = DATA_W'({rxDone, intFlag});
      default:   rdData = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xmitMode <= 1'b1;
      waitEn   <= 1'b0;
      ackHigh  <= 1'b0;
      irqEn    <= 1'b0;
    end else if (wrEn && (addr == ADDR_CTRL)) begin
      xmitMode <= wrData[0];
      waitEn   <= wrData[1];
      ackHigh  <= wrData[2];
      irqEn    <= wrData[3];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      dataReg  <= '0;
    end else begin
      if (stb.sampleBit) shiftReg <= {shiftReg[DATA_W-2:0], sdaIn};
      if (stb.byteDone)  dataReg  <= shiftReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intFlag <= 1'b0;
      rxDone  <= 1'b0;
    end else begin
      if (stb.waitMark || stb.byteDone)                     intFlag <= 1'b1;
      else if (wrEn && (addr == ADDR_STAT) && !wrData[0])   intFlag <= 1'b0;
      if (stb.byteDone)   rxDone <= 1'b1;
      else if (dataRead)  rxDone <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_rx_wait_master.sv
module i2c_rx_wait_master
  import i2c_rx_pkg::*;
#(
  parameter int PHASE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] hostAddr,
  input  logic       hostWr,
  input  logic [7:0] hostWrData,
  input  logic       hostRd,
  output logic [7:0] hostRdData,
  output logic       irq,
  input  logic       sclIn,
  output logic       sclOe,
  input  logic       sdaIn,
  output logic       sdaOe
);

  rxStrobe_t stb;
  rxState_t  ctrlState;
  logic      startReq;
  logic      xmitMode;
  logic      waitEn;
  logic      ackHigh;
  logic      irqEn;
  logic      intFlag;
  logic      rxDone;

  i2c_rx_ctrl #(.PHASE_CYCLES(PHASE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .waitEn(waitEn),
    .ackHigh(ackHigh), .intFlag(intFlag), .sclIn(sclIn), .stb(stb),
    .sclOe(sclOe), .sdaOe(sdaOe), .state(ctrlState)
  );

  i2c_rx_datapath #(.DATA_W(8)) u_dp (
    .clk(clk), .rstN(rstN), .addr(hostAddr), .wrEn(hostWr),
    .wrData(hostWrData), .rdEn(hostRd), .rdData(hostRdData), .sdaIn(sdaIn),
    .stb(stb), .startReq(startReq), .xmitMode(xmitMode), .waitEn(waitEn),
    .ackHigh(ackHigh), .irqEn(irqEn), .intFlag(intFlag), .rxDone(rxDone),
    .irq(irq)
  );

endmodule

// File: rtl/i2c_rx_checker.sv
module i2c_rx_checker
  import i2c_rx_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input rxState_t state,
  input logic     sclOe,
  input logic     sdaOe,
  input logic     ackHigh,
  input logic     irq,
  input logic     irqEn,
  input logic     intFlag,
  input logic     rxDone,
  input logic     xmitMode
);

  assert_tx_no_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && xmitMode) |=> !sclOe);

  assert_wait_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && intFlag) |=> sclOe);

  assert_ack_level_R5: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |-> !ackHigh);

  assert_done_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxDone) |-> intFlag);

  assert_irq_raise_R7: assert property (@(posedge clk) disable iff (!rstN)
    (intFlag && irqEn) |-> irq);

endmodule

bind i2c_rx_wait_master i2c_rx_checker u_chk (
  .clk(clk), .rstN(rstN), .state(ctrlState), .sclOe(sclOe), .sdaOe(sdaOe),
  .ackHigh(ackHigh), .irq(irq), .irqEn(irqEn), .intFlag(intFlag),
  .rxDone(rxDone), .xmitMode(xmitMode)
);

// File: tb/sim_i2c_rx_wait_master.sv
module sim_i2c_rx_wait_master;

  localparam int CLK_PERIOD = 10;
  localparam int PH = 5;
  localparam int NBYTES = 14;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] hostAddr = 2'd0;
  logic       hostWr = 1'b0;
  logic [7:0] hostWrData = 8'd0;
  logic       hostRd = 1'b0;
  logic [7:0] hostRdData;
  logic       irq, sclOe, sdaOe;
  logic       holdScl = 1'b0;
  logic       sclLine, sdaLine, slaveSdaLow;

  logic [7:0] slaveByte = 8'hFF;
  int         slaveIdx = 9;
  bit         seenRise = 1'b0;
  logic       ackSample = 1'b1;
  bit         stretchReq = 1'b0;
  int         stretchHigh = 0;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sclLine = !(sclOe || holdScl);
  assign slaveSdaLow = (slaveIdx >= 0 && slaveIdx < 8) ? !slaveByte[7 - slaveIdx[2:0]] : 1'b0;
  assign sdaLine = !(sdaOe || slaveSdaLow);

  i2c_rx_wait_master #(.PHASE_CYCLES(PH)) u0 (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostWrData(hostWrData), .hostRd(hostRd), .hostRdData(hostRdData),
    .irq(irq), .sclIn(sclLine), .sclOe(sclOe), .sdaIn(sdaLine), .sdaOe(sdaOe)
  );

  // slave model: advance bit after each full clock pulse
  always @(posedge sclLine) begin
    seenRise = 1'b1;
    if (slaveIdx == 8) ackSample = sdaLine;
  end
  always @(negedge sclLine) begin
    if (seenRise) begin
      slaveIdx = slaveIdx + 1;
      seenRise = 1'b0;
    end
  end

  // slave clock stretch on bit 3 of a chosen byte (R9)
  initial begin
    forever begin
      @(negedge clk);
      if (stretchReq && slaveIdx == 3 && !sclLine) begin
        holdScl = 1'b1;
        repeat (25) @(negedge clk);
        holdScl = 1'b0;
        #1;
        stretchHigh = 0;
        while (sclLine) begin
          stretchHigh++;
          @(negedge clk);
        end
        stretchReq = 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostRd = 1'b1;
    #1 d = hostRdData;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic loadSlave(input logic [7:0] b);
    slaveByte = b;
    slaveIdx = 0;
    seenRise = 1'b0;
  endtask

  function automatic logic [7:0] ctrlWord(input bit xm, input bit wm, input bit ah, input bit ie);
    return {4'b0, ie, ah, wm, xm};
  endfunction

  // follows one byte from launch to completion; flag is cleared at the end
  task automatic followByte(input bit wm, input bit ah, input bit ie);
    logic [7:0] st;
    if (wm) begin
      st = 8'h00;
      while (!st[0]) regRead(2'd2, st);
      check(st[1] == 1'b0, "R4 no completion at wait", st[1], 0);
      check(irq == ie, "R7 irq at wait flag", irq, ie);
      repeat (3*PH) @(negedge clk);
      check(sclLine == 1'b0, "R4 scl held low", sclLine, 0);
      check(slaveIdx == 8, "R4 no 9th clock during wait", slaveIdx, 8);
      regWrite(2'd2, 8'h01);
      regRead(2'd2, st);
      check(st[0] == 1'b1, "R10 write 1 keeps flag", st[0], 1);
      regWrite(2'd2, 8'h00);
    end
    st = 8'h00;
    while (!st[1]) begin
      regRead(2'd2, st);
      if (!wm && st[0] && !st[1]) check(1'b0, "R11 flag before completion", st, 2);
    end
    check(st[0] == 1'b1, "R6 flag with completion", st[0], 1);
    check(irq == ie, "R7 irq at completion", irq, ie);
    check(ackSample == ah, "R5 ack level", ackSample, ah);
    regWrite(2'd2, 8'h00);
    regRead(2'd2, st);
    check(st[0] == 1'b0 && irq == 1'b0, "R10 write 0 clears flag", st, 0);
  endtask

  logic [7:0] vals [NBYTES];
  bit         wms  [NBYTES];
  bit         acks [NBYTES];
  bit         ies  [NBYTES];

  initial begin
    logic [7:0] rd;
    int lowSeen;
    void'($urandom(32'd4242));
    for (int i = 0; i < NBYTES; i++) begin
      vals[i] = 8'($urandom);
      wms[i]  = 1'($urandom);
      acks[i] = 1'($urandom);
      ies[i]  = 1'($urandom);
    end
    vals[0] = 8'h00; wms[0] = 1; acks[0] = 0; ies[0] = 1;
    vals[1] = 8'hFF; wms[1] = 0; acks[1] = 0; ies[1] = 0;
    vals[2] = 8'hA5; wms[2] = 1; acks[2] = 1; ies[2] = 0;
    vals[3] = 8'h3C; wms[3] = 0; acks[3] = 0; ies[3] = 1;
    acks[NBYTES-1] = 1;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(sclOe == 0 && sdaOe == 0, "R1 pins released", {sclOe, sdaOe}, 0);
    check(irq == 0, "R1 irq low", irq, 0);
    regRead(2'd2, rd);
    check(rd == 8'h00, "R1 status reset", rd, 0);
    regRead(2'd1, rd);
    check(rd == 8'h01, "R1 control reset", rd, 1);

    // read in transmit mode launches nothing
    regRead(2'd0, rd);
    lowSeen = 0;
    repeat (50) begin @(negedge clk); if (!sclLine) lowSeen++; end
    check(lowSeen == 0, "R2 no clocks in transmit mode", lowSeen, 0);

    regWrite(2'd1, ctrlWord(0, wms[0], acks[0], ies[0]));
    loadSlave(vals[0]);
    regRead(2'd0, rd);
    for (int i = 0; i < NBYTES; i++) begin
      followByte(wms[i], acks[i], ies[i]);
      if (i == 3) check(stretchHigh == PH, "R9 stretched high phase length", stretchHigh, PH);
      if (i < NBYTES-1) begin
        regWrite(2'd1, ctrlWord(0, wms[i+1], acks[i+1], ies[i+1]));
        loadSlave(vals[i+1]);
        if (i + 1 == 3) stretchReq = 1'b1;
      end else begin
        regWrite(2'd1, ctrlWord(1, 0, 1, 0));
        repeat (30) @(negedge clk);
        check(slaveIdx == 9, "R2 no clock before next read", slaveIdx, 9);
      end
      regRead(2'd0, rd);
      check(rd == vals[i], (i == 3) ? "R9 data under stretch" : "R3 received byte", rd, vals[i]);
      regRead(2'd2, rd);
      check(rd[1] == 1'b0, "R8 data read clears completion", rd[1], 0);
    end
    repeat (40) @(negedge clk);
    check(slaveIdx == 9 && sclLine == 0, "R2 reception stopped", slaveIdx, 9);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule